// File: doc/BRIEF.md
# Performance Counter Snapshot Handshake

This block keeps a bank of event counters for one line port. Each counter counts single-cycle event strobes. When an update is requested, every enabled counter copies its running count into a holding register and restarts from zero in the same clock cycle. Software or the rest of the port reads the snapshot from the holding registers while counting continues underneath.

An update can come from one of two sources. In software mode the request input is a level: it is raised, held high until the port-level completion status goes high, and then dropped. In tick mode an internal generator issues a one-cycle request every `TICK_PERIOD` cycles. Each enabled counter raises its own done flag when it has taken its snapshot. The port reports completion only when every enabled counter's flag is set. A sticky latched bit records each rising edge of completion and can drive an interrupt.

Top module: `perf_snapshot`

## Requirements
- R1: While its enable bit in `active_i` is 1, a counter adds one for each cycle in which its strobe bit in `evt_i` is 1. Counter i uses strobe bit i, and its snapshot appears on `hold_o[i*CNT_W +: CNT_W]`.
- R2: A counter saturates at 2^CNT_W-1 and never wraps.
- R3: The update starts on a low-to-high change of the effective request. At that edge each enabled counter loads its count into its holding register and restarts. A strobe in that same cycle makes the new count 1, so no event is lost.
- R4: `done_all_o` goes high one clock after the effective request rises, with every holding register already updated. It stays high while the request stays high.
- R5: `done_all_o` falls one clock after the effective request drops.
- R6: A request held high causes exactly one snapshot. No holding register changes again until the request has dropped and risen once more.
- R7: A counter whose `active_i` bit is 0 ignores its strobes, keeps its holding register unchanged across updates, and is left out of the completion AND.
- R8: With `tick_mode_i` = 1, `req_i` is ignored. The internal request is a one-cycle pulse in the `TICK_PERIOD`-th cycle after tick mode is entered and every `TICK_PERIOD` cycles after that, so `done_all_o` is high for exactly one cycle per tick.
- R9: `done_latch_o` sets one clock after each rising edge of `done_all_o`. It clears one clock after a cycle with `latch_clr_i` = 1. When a set and a clear fall in the same cycle, the set wins.
- R10: `irq_o` is 1 exactly when `done_latch_o` is 1 and `irq_en_i` is 1.
- R11: After reset, all counts and holding registers are 0 and `done_all_o`, `done_latch_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_CNT | One event strobe per counter |
| active_i | input | NUM_CNT | Counter enable mask, 1 = active |
| tick_mode_i | input | 1 | 0 = software request, 1 = internal periodic tick |
| req_i | input | 1 | Software update request (level, four-phase) |
| latch_clr_i | input | 1 | Clears the latched completion bit |
| irq_en_i | input | 1 | Interrupt enable for the latched bit |
| hold_o | output | NUM_CNT*CNT_W | Holding registers, counter i at bits i*CNT_W upward |
| done_all_o | output | 1 | AND of the done flags of all active counters |
| done_latch_o | output | 1 | Sticky record of completion rising edges |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a counter sitting at saturation in the same cycle that an update starts, together with a strobe in that cycle. To get there, the stimulus drives a long directed run of strobes into one counter, then raises the request while strobing. Other hard-to-reach cases are a clear and a set of the latched bit landing on the same edge, and a request on `req_i` that arrives while tick mode is in charge. These come from directed steps timed against the bench's own tick count. Random phases then mix strobes, request lengths, masks, modes and clears.

// File: rtl/perf_snap_pkg.sv
package perf_snap_pkg;

  typedef enum logic {
    MODE_SW   = 1'b0,
    MODE_TICK = 1'b1
  } upd_mode_e;

  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/pcs_tick_gen.sv
module pcs_tick_gen #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_q <= '0;
    else if (!run_i)       phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end

  assign tick_o = run_i && (phase_q == LAST);
endmodule

// File: rtl/pcs_count_slice.sv
module pcs_count_slice #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             evt_i,
  input  logic             start_i,
  input  logic             req_lvl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             done_o
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic e);
    return (e && (v != '1)) ? v + 1'b1 : v;
  endfunction

  logic [CNT_W-1:0] cnt_q, hold_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (active_i) begin
      if (start_i) begin
        hold_q <= cnt_q;
        cnt_q  <= {{(CNT_W-1){1'b0}}, evt_i};
      end else begin
        cnt_q  <= bump(cnt_q, evt_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= active_i && (start_i || (done_q && req_lvl_i));
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
  assign done_o = done_q;
endmodule

// File: rtl/pcs_status.sv
module pcs_status #(
  parameter int NUM_CNT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] done_vec_i,
  input  logic [NUM_CNT-1:0] active_i,
  input  logic               busy_i,
  input  logic               clr_i,
  output logic               done_all_o,
  output logic               latch_o
);
  import perf_snap_pkg::*;

  logic done_all, done_all_q, latch_q;

  assign done_all = busy_i && (&(done_vec_i | ~active_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_all_q <= 1'b0;
      latch_q    <= 1'b0;
    end else begin
      done_all_q <= done_all;
      latch_q    <= rise_of(done_all, done_all_q) || (latch_q && !clr_i);
    end
  end

  assign done_all_o = done_all;
  assign latch_o    = latch_q;
endmodule

// File: rtl/perf_snapshot.sv
module perf_snapshot #(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 8,
  parameter int TICK_PERIOD = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       evt_i,
  input  logic [NUM_CNT-1:0]       active_i,
  input  logic                     tick_mode_i,
  input  logic                     req_i,
  input  logic                     latch_clr_i,
  input  logic                     irq_en_i,
  output logic [NUM_CNT*CNT_W-1:0] hold_o,
  output logic                     done_all_o,
  output logic                     done_latch_o,
  output logic                     irq_o
);
  import perf_snap_pkg::*;

  localparam int FLAT_W = NUM_CNT * CNT_W;

  upd_mode_e          mode;
  logic               tick_pulse;
  logic               eff_req, eff_req_q, snap_start, busy_q;
  logic [NUM_CNT-1:0] done_vec;
  logic [FLAT_W-1:0]  cnt_flat;

  assign mode = upd_mode_e'(tick_mode_i);

  pcs_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(mode == MODE_TICK), .tick_o(tick_pulse)
  );

  assign eff_req    = (mode == MODE_TICK) ? tick_pulse : req_i;
  assign snap_start = rise_of(eff_req, eff_req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_req_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      eff_req_q <= eff_req;
      busy_q    <= snap_start || (busy_q && eff_req);
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_slice
    pcs_count_slice #(.CNT_W(CNT_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active_i[g]),
      .evt_i    (evt_i[g]),
      .start_i  (snap_start),
      .req_lvl_i(eff_req),
      .cnt_o    (cnt_flat[g*CNT_W +: CNT_W]),
      .hold_o   (hold_o[g*CNT_W +: CNT_W]),
      .done_o   (done_vec[g])
    );
  end

  pcs_status #(.NUM_CNT(NUM_CNT)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_vec_i(done_vec),
    .active_i  (active_i),
    .busy_i    (busy_q),
    .clr_i     (latch_clr_i),
    .done_all_o(done_all_o),
    .latch_o   (done_latch_o)
  );

  assign irq_o = done_latch_o && irq_en_i;
endmodule

// File: rtl/perf_snapshot_chk.sv
module perf_snapshot_chk #(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 8,
  parameter int TICK_PERIOD = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     eff_req,
  input logic                     snap_start,
  input logic                     tick_pulse,
  input logic [NUM_CNT-1:0]       active_i,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [NUM_CNT*CNT_W-1:0] hold_o,
  input logic                     done_all_o,
  input logic                     done_latch_o,
  input logic                     irq_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_done_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eff_req) |=> done_all_o);

  assert_done_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_all_o && !eff_req) |=> !done_all_o);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_start |=> $stable(hold_o));

  assert_latch_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_all_o) |=> done_latch_o);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_latch_o);

  if (TICK_PERIOD > 1) begin : g_tick
    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick_pulse |=> !tick_pulse);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i[g] && !snap_start && cnt_flat[g*CNT_W +: CNT_W] == TOP)
        |=> cnt_flat[g*CNT_W +: CNT_W] == TOP);

    assert_snap_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_start && active_i[g])
        |=> hold_o[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]));
  end
endmodule

bind perf_snapshot perf_snapshot_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .TICK_PERIOD(TICK_PERIOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .eff_req(eff_req), .snap_start(snap_start),
  .tick_pulse(tick_pulse), .active_i(active_i), .cnt_flat(cnt_flat),
  .hold_o(hold_o), .done_all_o(done_all_o), .done_latch_o(done_latch_o),
  .irq_o(irq_o)
);

// File: tb/perf_snapshot_test.sv
module perf_snapshot_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 8;
  localparam int P = 16;
  localparam int MAXV = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   evt_i = '0, active_i = '1;
  logic           tick_mode_i = 1'b0, req_i = 1'b0, latch_clr_i = 1'b0, irq_en_i = 1'b0;
  logic [N*W-1:0] hold_o;
  logic           done_all_o, done_latch_o, irq_o;

  int checks = 0, errors = 0;
  int m_cnt [N];
  int m_hold[N];
  int m_tcnt = 0;
  bit m_prev = 0, m_busy = 0, m_busy_q = 0, m_latch = 0;

  perf_snapshot #(.NUM_CNT(N), .CNT_W(W), .TICK_PERIOD(P)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sat_add(input int v, input bit e);
    return (v + e > MAXV) ? MAXV : v + e;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_ports(input string tag);
    for (int i = 0; i < N; i++) chk(tag, $sformatf("hold[%0d]", i), int'(hold_o[i*W +: W]), m_hold[i]);
    chk(tag, "done_all", int'(done_all_o), int'(m_busy));
    chk(tag, "done_latch", int'(done_latch_o), int'(m_latch));
    chk(tag, "irq", int'(irq_o), int'(m_latch && irq_en_i));
  endtask

  // one clock: drive at negedge, advance model over the posedge, check at next negedge
  task automatic step(input logic [N-1:0] ev, input string tag);
    bit eff, start;
    evt_i = ev;
    eff   = tick_mode_i ? (m_tcnt == P-1) : req_i;
    start = eff && !m_prev;
    for (int i = 0; i < N; i++) begin
      if (active_i[i]) begin
        if (start) begin m_hold[i] = m_cnt[i]; m_cnt[i] = ev[i]; end
        else m_cnt[i] = sat_add(m_cnt[i], ev[i]);
      end
    end
    m_latch  = (m_busy && !m_busy_q) || (m_latch && !latch_clr_i);
    m_busy_q = m_busy;
    m_busy   = start || (m_busy && eff);
    m_prev   = eff;
    m_tcnt   = !tick_mode_i ? 0 : ((m_tcnt == P-1) ? 0 : m_tcnt + 1);
    @(negedge clk);
    check_ports(tag);
  endtask

  task automatic snap(input string tag, input int hold_len);
    req_i = 1'b1;
    step('0, tag);
    for (int k = 0; k < hold_len; k++) step(4'b1111, tag);
    req_i = 1'b0;
    step('0, tag);
    step('0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_hold[i] = 0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check_ports("R11");
    rst_n = 1'b1;
    @(negedge clk);
    check_ports("R11");

    // R1: counting with distinct patterns, then snapshot
    for (int k = 0; k < 12; k++) step(N'(k), "R1");
    snap("R1", 0);
    // R3: strobe in the start cycle counts in the new period
    step(4'b0011, "R3");
    req_i = 1'b1; step(4'b0101, "R3");
    req_i = 1'b0; step('0, "R3"); step('0, "R3");
    snap("R3", 0);
    chk("R3", "hold[0] new period", int'(hold_o[0 +: W]), 1);
    // R4/R6: long held request, one snapshot only; R5: fall one clock after drop
    for (int k = 0; k < 5; k++) step(4'b1001, "R6");
    snap("R6", 8);
    chk("R5", "done_all after drop", int'(done_all_o), 0);

    // R2: saturation, strobe in the start cycle too
    for (int k = 0; k < 300; k++) step(4'b0001, "R2");
    req_i = 1'b1; step(4'b0001, "R2");
    chk("R2", "hold[0] saturated", int'(hold_o[0 +: W]), MAXV);
    req_i = 1'b0; step('0, "R2"); step('0, "R2");

    // R7: masked counters ignore strobes and keep their holds
    active_i = 4'b1010;
    for (int k = 0; k < 6; k++) step(4'b1111, "R7");
    snap("R7", 2);
    active_i = 4'b1111;
    for (int k = 0; k < 3; k++) step(4'b1111, "R7");
    snap("R7", 1);

    // R9: plain clear, then clear on the same edge as a set
    irq_en_i = 1'b1; step('0, "R10");
    latch_clr_i = 1'b1; step('0, "R9");
    latch_clr_i = 1'b0; step('0, "R9");
    req_i = 1'b1; step('0, "R9");
    latch_clr_i = 1'b1; step('0, "R9");
    latch_clr_i = 1'b0; step('0, "R9");
    chk("R9", "set wins over clear", int'(done_latch_o), 1);
    req_i = 1'b0; step('0, "R9"); step('0, "R9");
    irq_en_i = 1'b0; step('0, "R10");

    // R8: tick mode with req_i toggling
    tick_mode_i = 1'b1;
    for (int k = 0; k < 3*P + 3; k++) begin
      req_i = k[1];
      step(N'($urandom), "R8");
    end
    tick_mode_i = 1'b0; req_i = 1'b0;
    step('0, "R8"); step('0, "R8");

    // random phases
    for (int blk = 0; blk < 12; blk++) begin
      req_i = 1'b0; latch_clr_i = 1'b0;
      step('0, "R1"); step('0, "R1");
      active_i    = N'($urandom);
      tick_mode_i = ($urandom % 3) == 0;
      irq_en_i    = $urandom % 2;
      for (int k = 0; k < 250; k++) begin
        if (($urandom % 9) == 0) req_i = ~req_i;
        latch_clr_i = ($urandom % 7) == 0;
        step(N'($urandom), tick_mode_i ? "R8" : "R3");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule